// File: doc/BRIEF.md
# Speculative Access Tracker with RAW Violation Detection

This block sits beside a private cache in a machine that runs speculative tasks in parallel. It keeps a small, fully associative table of speculative access records. Each record belongs to one cache line and one task. Every record holds a written mask, an exposed-read mask and the task number that owns it. The local core reports its loads and stores. The coherence side reports write-invalidation snoops, and each snoop carries the task number of the writer. Task numbers are ordered: a smaller number is an older task, earlier in sequential order.

When an older task writes a datum that a younger task read before writing it, a read-after-write dependence has been broken. The block then requests a squash for the oldest such younger task. It also drops the records of that task and of every task younger than it. A commit drops the records of one task.

A parameter selects word or line granularity. At line granularity, any earlier write or exposed read by a younger task anywhere in the line triggers a squash. This trades false-sharing squashes for a smaller table.

Top module: `spec_raw_detector`

## Requirements
- R1: After reset, squash_valid is low and the table holds no records, so a snoop without earlier accesses raises no squash.
- R2: A load sets the exposed-read bit of its word only when the same task has not already written that word (at line granularity, anything in that line). A later older write then squashes only a task whose exposed-read bit is set.
- R3: A snoop with writer number W on line L and word X is a violation for a record of task T on line L when W < T and the record has the exposed-read bit for X. In the cycle after the snoop, squash_valid is high and squash_tid equals T.
- R4: A snoop whose writer number is greater than or equal to the record's task number never raises a squash.
- R5: At word granularity, a snoop to a different word of the line raises no squash, and a record that only has written bits (a write-after-read or write-after-write conflict) raises no squash.
- R6: At line granularity, the snoop word is ignored, and a younger record on the line with any exposed-read or written bit raises a squash (false sharing and write-after-write conflicts squash).
- R7: When several records violate on the same snoop, squash_tid is the smallest violating task number.
- R8: In the cycle a violation with victim V is detected, every record whose task number is V or larger is removed.
- R9: A commit with task number C removes every record of task C in that cycle, including a record allocated in the same cycle.
- R10: A local access that matches no record while every entry is in use is not recorded.
- R11: Repeated accesses by one task to one line share a single record, so no two valid records carry the same line and task.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid | input | 1 | Local speculative access present |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_line | input | LINE_W | Line address of the access |
| acc_word | input | $clog2(WORDS) | Word index within the line |
| acc_tid | input | TID_W | Task number of the accessing task |
| snp_valid | input | 1 | Incoming write-invalidation snoop present |
| snp_line | input | LINE_W | Line address written by the remote task |
| snp_word | input | $clog2(WORDS) | Word written by the remote task |
| snp_tid | input | TID_W | Task number of the remote writer |
| cmt_valid | input | 1 | Commit of a task |
| cmt_tid | input | TID_W | Task number that commits |
| squash_valid | output | 1 | Squash request, one cycle after the violating snoop |
| squash_tid | output | TID_W | Oldest violating task number |

## Verification
On every cycle the assertions check four things. A squash always names a task younger than the snoop writer. A word that was written never later gains an exposed-read bit in the same record. Commit and squash remove the records they target on the next edge. No line and task pair is held twice. Other behaviour can only be seen through the bench scenarios, where a behavioural model is compared with both a word-grain and a line-grain instance on every clock. These scenarios cover the choice of the oldest victim among several, the removal of younger tasks in the same squash, the difference between false sharing and distinct words, and the dropping of accesses when the table is full.

// File: rtl/srd_pkg.sv
package srd_pkg;
  typedef enum logic {
    GRAN_LINE = 1'b0,
    GRAN_WORD = 1'b1
  } gran_e;
endpackage

// File: rtl/srd_entry_cmp.sv
module srd_entry_cmp
  import srd_pkg::*;
#(
  parameter int    LINE_W = 12,
  parameter int    TID_W  = 3,
  parameter int    WORDS  = 4,
  parameter gran_e GRAN   = GRAN_WORD
) (
  input  logic              ent_valid,
  input  logic [LINE_W-1:0] ent_line,
  input  logic [TID_W-1:0]  ent_tid,
  input  logic [WORDS-1:0]  ent_swr,
  input  logic [WORDS-1:0]  ent_erd,
  input  logic [LINE_W-1:0] acc_line,
  input  logic [TID_W-1:0]  acc_tid,
  input  logic              snp_valid,
  input  logic [LINE_W-1:0] snp_line,
  input  logic [TID_W-1:0]  snp_tid,
  input  logic [WORDS-1:0]  snp_mask,
  output logic              hit,
  output logic              viol
);
  localparam bit LINE_MODE = (GRAN == GRAN_LINE);

  logic conflict;
  logic younger;

  // Line mode: any footprint in the line conflicts (false sharing, WAW).
  assign conflict = LINE_MODE ? ((|ent_erd) || (|ent_swr)) : (|(ent_erd & snp_mask));
  assign younger  = snp_tid < ent_tid;
  assign hit      = ent_valid && (ent_line == acc_line) && (ent_tid == acc_tid);
  assign viol     = snp_valid && ent_valid && (ent_line == snp_line) && younger && conflict;
endmodule

// File: rtl/srd_first_free.sv
module srd_first_free #(
  parameter int N = 8
) (
  input  logic [N-1:0] free,
  output logic [N-1:0] sel,
  output logic         any
);
  always_comb begin
    sel = '0;
    any = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (free[i] && !any) begin
        sel[i] = 1'b1;
        any    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/srd_oldest_pick.sv
module srd_oldest_pick #(
  parameter int N     = 8,
  parameter int TID_W = 3
) (
  input  logic [N-1:0]     cand,
  input  logic [TID_W-1:0] tids [N],
  output logic             any,
  output logic [TID_W-1:0] tid
);
  always_comb begin
    any = 1'b0;
    tid = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!any || (tids[i] < tid))) begin
        tid = tids[i];
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/spec_raw_detector.sv
module spec_raw_detector
  import srd_pkg::*;
#(
  parameter int    N_ENT  = 8,
  parameter int    LINE_W = 12,
  parameter int    TID_W  = 3,
  parameter int    WORDS  = 4,
  parameter gran_e GRAN   = GRAN_WORD
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       acc_valid,
  input  logic                       acc_write,
  input  logic [LINE_W-1:0]          acc_line,
  input  logic [$clog2(WORDS)-1:0]   acc_word,
  input  logic [TID_W-1:0]           acc_tid,
  input  logic                       snp_valid,
  input  logic [LINE_W-1:0]          snp_line,
  input  logic [$clog2(WORDS)-1:0]   snp_word,
  input  logic [TID_W-1:0]           snp_tid,
  input  logic                       cmt_valid,
  input  logic [TID_W-1:0]           cmt_tid,
  output logic                       squash_valid,
  output logic [TID_W-1:0]           squash_tid
);
  localparam int WIDX_W = $clog2(WORDS);

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_sync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  // Per-access word masks; the granularity picks the form.
  logic [WORDS-1:0] acc_mask;
  logic [WORDS-1:0] snp_mask;

  generate
    if (GRAN == GRAN_WORD) begin : g_word
      assign acc_mask = WORDS'(1) << acc_word;
      assign snp_mask = WORDS'(1) << snp_word;
    end else begin : g_line
      assign acc_mask = WORDS'(1);
      assign snp_mask = WORDS'(1);
    end
  endgenerate

  // Table state
  logic [N_ENT-1:0]  ent_valid_q, ent_valid_d;
  logic [LINE_W-1:0] ent_line_q [N_ENT];
  logic [LINE_W-1:0] ent_line_d [N_ENT];
  logic [TID_W-1:0]  ent_tid_q  [N_ENT];
  logic [TID_W-1:0]  ent_tid_d  [N_ENT];
  logic [WORDS-1:0]  ent_swr_q  [N_ENT];
  logic [WORDS-1:0]  ent_swr_d  [N_ENT];
  logic [WORDS-1:0]  ent_erd_q  [N_ENT];
  logic [WORDS-1:0]  ent_erd_d  [N_ENT];

  logic [N_ENT-1:0]  hit_vec;
  logic [N_ENT-1:0]  viol_vec;
  logic [N_ENT-1:0]  free_sel;
  logic              free_any;
  logic              viol_any;
  logic [TID_W-1:0]  victim;
  logic              alloc_req;
  logic              tbl_en;

  for (genvar gi = 0; gi < N_ENT; gi++) begin : g_cmp
    srd_entry_cmp #(
      .LINE_W (LINE_W),
      .TID_W  (TID_W),
      .WORDS  (WORDS),
      .GRAN   (GRAN)
    ) u_cmp (
      .ent_valid (ent_valid_q[gi]),
      .ent_line  (ent_line_q[gi]),
      .ent_tid   (ent_tid_q[gi]),
      .ent_swr   (ent_swr_q[gi]),
      .ent_erd   (ent_erd_q[gi]),
      .acc_line  (acc_line),
      .acc_tid   (acc_tid),
      .snp_valid (snp_valid),
      .snp_line  (snp_line),
      .snp_tid   (snp_tid),
      .snp_mask  (snp_mask),
      .hit       (hit_vec[gi]),
      .viol      (viol_vec[gi])
    );
  end

  srd_first_free #(.N(N_ENT)) u_free (
    .free (~ent_valid_q),
    .sel  (free_sel),
    .any  (free_any)
  );

  srd_oldest_pick #(.N(N_ENT), .TID_W(TID_W)) u_pick (
    .cand (viol_vec),
    .tids (ent_tid_q),
    .any  (viol_any),
    .tid  (victim)
  );

  assign alloc_req = acc_valid && !(|hit_vec) && free_any;
  assign tbl_en    = acc_valid || snp_valid || cmt_valid;

  // Next state: access update, then allocation, then commit and squash removal.
  always_comb begin
    for (int i = 0; i < N_ENT; i++) begin
      ent_valid_d[i] = ent_valid_q[i];
      ent_line_d[i]  = ent_line_q[i];
      ent_tid_d[i]   = ent_tid_q[i];
      ent_swr_d[i]   = ent_swr_q[i];
      ent_erd_d[i]   = ent_erd_q[i];
      if (acc_valid && hit_vec[i]) begin
        if (acc_write) begin
          ent_swr_d[i] = ent_swr_q[i] | acc_mask;
        end else if ((ent_swr_q[i] & acc_mask) == '0) begin
          ent_erd_d[i] = ent_erd_q[i] | acc_mask;
        end
      end
      if (alloc_req && free_sel[i]) begin
        ent_valid_d[i] = 1'b1;
        ent_line_d[i]  = acc_line;
        ent_tid_d[i]   = acc_tid;
        ent_swr_d[i]   = acc_write ? acc_mask : '0;
        ent_erd_d[i]   = acc_write ? '0 : acc_mask;
      end
      if (cmt_valid && (ent_tid_d[i] == cmt_tid)) begin
        ent_valid_d[i] = 1'b0;
      end
      if (viol_any && (ent_tid_d[i] >= victim)) begin
        ent_valid_d[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ent_valid_q <= '0;
      for (int i = 0; i < N_ENT; i++) begin
        ent_line_q[i] <= '0;
        ent_tid_q[i]  <= '0;
        ent_swr_q[i]  <= '0;
        ent_erd_q[i]  <= '0;
      end
    end else if (tbl_en) begin
      ent_valid_q <= ent_valid_d;
      for (int i = 0; i < N_ENT; i++) begin
        ent_line_q[i] <= ent_line_d[i];
        ent_tid_q[i]  <= ent_tid_d[i];
        ent_swr_q[i]  <= ent_swr_d[i];
        ent_erd_q[i]  <= ent_erd_d[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      squash_valid <= 1'b0;
      squash_tid   <= '0;
    end else begin
      squash_valid <= viol_any;
      if (viol_any) squash_tid <= victim;
    end
  end

  // Checks
  logic dup_found;
  always_comb begin
    dup_found = 1'b0;
    for (int i = 0; i < N_ENT; i++) begin
      for (int j = i + 1; j < N_ENT; j++) begin
        if (ent_valid_q[i] && ent_valid_q[j] &&
            (ent_line_q[i] == ent_line_q[j]) && (ent_tid_q[i] == ent_tid_q[j]))
          dup_found = 1'b1;
      end
    end
  end

  AST_SQUASH_YOUNGER: assert property (@(posedge clk) disable iff (!rst_sn)
    squash_valid |-> ($past(snp_valid) && (squash_tid > $past(snp_tid)))); // R4

  AST_UNIQUE_RECORD: assert property (@(posedge clk) disable iff (!rst_sn)
    !dup_found); // R11

  for (genvar gc = 0; gc < N_ENT; gc++) begin : g_chk
    AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_sn)
      (cmt_valid && ent_valid_q[gc] && (ent_tid_q[gc] == cmt_tid)) |=> !ent_valid_q[gc]); // R9

    AST_SQUASH_CLEARS: assert property (@(posedge clk) disable iff (!rst_sn)
      (viol_any && ent_valid_q[gc] && (ent_tid_q[gc] >= victim)) |=> !ent_valid_q[gc]); // R8

    for (genvar gw = 0; gw < WORDS; gw++) begin : g_word_chk
      AST_NO_EXPOSED_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_sn)
        (ent_valid_q[gc] && ent_swr_q[gc][gw] && !ent_erd_q[gc][gw]) |=> !ent_erd_q[gc][gw]); // R2
    end
  end

  // WIDX_W documents the index width used by the word ports.
  if (WIDX_W < 1) begin : g_bad_words
    initial $display("spec_raw_detector: WORDS must be at least 2");
  end
endmodule

// File: tb/tb_spec_raw_detector.sv
module tb_spec_raw_detector;
  import srd_pkg::*;

  localparam int NE     = 8;
  localparam int LINE_W = 12;
  localparam int TID_W  = 3;
  localparam int WORDS  = 4;
  localparam int WIDX_W = $clog2(WORDS);

  logic clk;
  logic rst_n;
  logic acc_valid, acc_write, snp_valid, cmt_valid;
  logic [LINE_W-1:0] acc_line, snp_line;
  logic [WIDX_W-1:0] acc_word, snp_word;
  logic [TID_W-1:0]  acc_tid, snp_tid, cmt_tid;
  logic              sq_v [2];
  logic [TID_W-1:0]  sq_t [2];

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";

  // Behavioural model, index 0 = word grain, 1 = line grain
  int mv [2][NE];
  int ml [2][NE];
  int mt [2][NE];
  int msw[2][NE];
  int mer[2][NE];
  int exp_v[2];
  int exp_t[2];
  int b_av, b_aw, b_al, b_awd, b_at, b_sv, b_sl, b_swd, b_st, b_cv, b_ct;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  spec_raw_detector #(.N_ENT(NE), .LINE_W(LINE_W), .TID_W(TID_W), .WORDS(WORDS),
                      .GRAN(GRAN_WORD)) dut (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_line(acc_line),
    .acc_word(acc_word), .acc_tid(acc_tid),
    .snp_valid(snp_valid), .snp_line(snp_line), .snp_word(snp_word), .snp_tid(snp_tid),
    .cmt_valid(cmt_valid), .cmt_tid(cmt_tid),
    .squash_valid(sq_v[0]), .squash_tid(sq_t[0])
  );

  spec_raw_detector #(.N_ENT(NE), .LINE_W(LINE_W), .TID_W(TID_W), .WORDS(WORDS),
                      .GRAN(GRAN_LINE)) dut_ln (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_line(acc_line),
    .acc_word(acc_word), .acc_tid(acc_tid),
    .snp_valid(snp_valid), .snp_line(snp_line), .snp_word(snp_word), .snp_tid(snp_tid),
    .cmt_valid(cmt_valid), .cmt_tid(cmt_tid),
    .squash_valid(sq_v[1]), .squash_tid(sq_t[1])
  );

  task automatic model_clear();
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < NE; i++) begin
        mv[m][i] = 0; ml[m][i] = 0; mt[m][i] = 0; msw[m][i] = 0; mer[m][i] = 0;
      end
      exp_v[m] = 0; exp_t[m] = 0;
    end
  endtask

  task automatic model_step(input int m);
    int ab, sb, vf, vt, hit, fr;
    ab = 1 << ((m == 0) ? b_awd : 0);
    sb = 1 << ((m == 0) ? b_swd : 0);
    vf = 0; vt = 0;
    if (b_sv != 0) begin
      for (int i = 0; i < NE; i++) begin
        if (mv[m][i] != 0 && ml[m][i] == b_sl && mt[m][i] > b_st &&
            ((mer[m][i] & sb) != 0 || (m == 1 && (msw[m][i] != 0 || mer[m][i] != 0)))) begin
          if (vf == 0 || mt[m][i] < vt) vt = mt[m][i];
          vf = 1;
        end
      end
    end
    hit = -1; fr = -1;
    for (int i = NE - 1; i >= 0; i--) begin
      if (mv[m][i] != 0 && ml[m][i] == b_al && mt[m][i] == b_at) hit = i;
      if (mv[m][i] == 0) fr = i;
    end
    if (b_av != 0) begin
      if (hit >= 0) begin
        if (b_aw != 0) msw[m][hit] = msw[m][hit] | ab;
        else if ((msw[m][hit] & ab) == 0) mer[m][hit] = mer[m][hit] | ab;
      end else if (fr >= 0) begin
        mv[m][fr] = 1; ml[m][fr] = b_al; mt[m][fr] = b_at;
        msw[m][fr] = (b_aw != 0) ? ab : 0;
        mer[m][fr] = (b_aw != 0) ? 0 : ab;
      end
    end
    for (int i = 0; i < NE; i++) begin
      if (b_cv != 0 && mt[m][i] == b_ct) mv[m][i] = 0;
      if (vf != 0 && mt[m][i] >= vt) mv[m][i] = 0;
    end
    exp_v[m] = vf; exp_t[m] = vt;
  endtask

  task automatic compare();
    for (int m = 0; m < 2; m++) begin
      checks++;
      if ((sq_v[m] !== (exp_v[m] != 0)) ||
          (exp_v[m] != 0 && int'(sq_t[m]) != exp_t[m])) begin
        fails++;
        $display("FAIL %s %s: squash_valid=%0d squash_tid=%0d expected valid=%0d tid=%0d",
                 cur_req, (m == 0) ? "word" : "line", sq_v[m], sq_t[m], exp_v[m], exp_t[m]);
      end
    end
  endtask

  task automatic cyc(input int av, aw, al, awd, at, sv, sl, swd, st, cv, ct);
    @(negedge clk);
    compare();
    b_av = av; b_aw = aw; b_al = al; b_awd = awd; b_at = at;
    b_sv = sv; b_sl = sl; b_swd = swd; b_st = st; b_cv = cv; b_ct = ct;
    acc_valid = av[0]; acc_write = aw[0]; acc_line = LINE_W'(al);
    acc_word = WIDX_W'(awd); acc_tid = TID_W'(at);
    snp_valid = sv[0]; snp_line = LINE_W'(sl); snp_word = WIDX_W'(swd);
    snp_tid = TID_W'(st); cmt_valid = cv[0]; cmt_tid = TID_W'(ct);
    model_step(0);
    model_step(1);
  endtask

  task automatic idle();                      cyc(0,0,0,0,0, 0,0,0,0, 0,0); endtask
  task automatic rd(input int t, l, w);       cyc(1,0,l,w,t, 0,0,0,0, 0,0); endtask
  task automatic wr(input int t, l, w);       cyc(1,1,l,w,t, 0,0,0,0, 0,0); endtask
  task automatic snp(input int t, l, w);      cyc(0,0,0,0,0, 1,l,w,t, 0,0); endtask
  task automatic cmt(input int t);            cyc(0,0,0,0,0, 0,0,0,0, 1,t); endtask
  task automatic clear_all();
    for (int t = 0; t < 8; t++) cmt(t);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    rst_n = 1'b0;
    acc_valid = 0; acc_write = 0; acc_line = '0; acc_word = '0; acc_tid = '0;
    snp_valid = 0; snp_line = '0; snp_word = '0; snp_tid = '0;
    cmt_valid = 0; cmt_tid = '0;
    b_av = 0; b_aw = 0; b_al = 0; b_awd = 0; b_at = 0;
    b_sv = 0; b_sl = 0; b_swd = 0; b_st = 0; b_cv = 0; b_ct = 0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, and a snoop on an empty table raises nothing
    cur_req = "R1";
    repeat (4) idle();
    snp(0, 5, 0); idle();

    // R2 R3: exposed read by task 2, older writer 1 on the same word
    cur_req = "R3";
    rd(2, 10, 1); snp(1, 10, 1); idle(); idle();

    // R2: write then read leaves no exposed bit (word); line grain squashes via write
    cur_req = "R2";
    wr(3, 20, 0); rd(3, 20, 0); snp(1, 20, 0); idle(); idle();
    clear_all();

    // R4: younger or equal writer never squashes
    cur_req = "R4";
    rd(1, 30, 0); snp(5, 30, 0); idle(); snp(1, 30, 0); idle(); cmt(1);

    // R5 R6: different word of the same line
    cur_req = "R5/R6 false sharing";
    rd(4, 40, 2); snp(2, 40, 3); idle(); idle();
    clear_all();
    // R5: write-only younger record (WAW) squashes only at line grain (R6)
    cur_req = "R5/R6 waw";
    wr(6, 45, 1); snp(2, 45, 1); idle(); idle();
    clear_all();

    // R7: several violators, oldest wins; R8: all of them removed
    cur_req = "R7";
    rd(5, 50, 0); rd(6, 50, 0); rd(3, 50, 0); snp(2, 50, 0); idle();
    cur_req = "R8";
    snp(1, 50, 0); idle(); idle();
    clear_all();

    // R9: commit removes the record
    cur_req = "R9";
    rd(7, 60, 0); cmt(7); snp(0, 60, 0); idle();
    // R9: allocation and commit of the same task in one cycle
    cyc(1,0,61,0,4, 0,0,0,0, 1,4); snp(0, 61, 0); idle();
    clear_all();

    // R10 R11: fill the table, repeat an access, overflow is dropped
    cur_req = "R11";
    for (int i = 0; i < NE; i++) rd(7, 100 + i, 0);
    rd(7, 100, 0); rd(7, 100, 1);
    cur_req = "R10";
    rd(7, 200, 0); snp(0, 200, 0); idle();
    cur_req = "R11";
    snp(0, 107, 0); idle(); idle();
    clear_all();

    // Mixed traffic
    cur_req = "R3 mixed";
    seed = 12345;
    for (int n = 0; n < 400; n++) begin
      int r, k;
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      r = seed >> 4;
      k = r % 6;
      cyc((k < 3) ? 1 : 0, (k == 1) ? 1 : 0, (r >> 3) % 3, (r >> 5) % 4, (r >> 7) % 8,
          (k >= 2 && k < 5) ? 1 : 0, (r >> 10) % 3, (r >> 12) % 4, (r >> 14) % 8,
          (k == 5) ? 1 : 0, (r >> 17) % 8);
    end
    idle(); idle();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule